// File: doc/BRIEF.md
# Dead Band Period Timer

The block is an 8-bit dead-band slice. It turns one PWM reference input into two complementary outputs that never overlap. Output A follows the high phase of the reference and output B follows the low phase. Every change of the reference level starts a dead-band interval, during which both outputs are held low. A synchronous down counter times the interval, and it restarts from the programmed period value.

Software reaches the slice through a synchronous 8-bit register bus with a 2-bit address. The bus gives access to a period register, a buffer register and a one-bit control register. The count itself cannot be written directly. While the slice is disabled, a read of the count address copies the count into the buffer register, where it can be read back. A period written while the slice is disabled also preloads the counter. While the slice is enabled, a new period reaches the counter only when the counter reloads.

Top module: `deadband_timer`

## Requirements
- R1: After reset the slice is disabled, both outputs are low, the period, count and buffer are 00h, and every address reads 00h.
- R2: Address map: 0 is the count, 1 is the period (write only, reads 00h), 2 is the buffer (read/write) and 3 is control, where bit 0 is the enable and reads back. `rdata` is combinational and is 00h whenever `rd_en` is low.
- R3: With period N, a rising edge of `ref_in` sampled at a clock edge drives both outputs low for exactly N+1 clock cycles after that edge, and then `out_a` goes high.
- R4: A period of 00h gives a dead band of one clock cycle.
- R5: A falling edge of `ref_in` behaves like a rising edge, with `out_b` in place of `out_a`.
- R6: If `ref_in` changes again before the interval ends, the counter restarts from the period. Both outputs stay low until a full N+1 cycles have passed since the last change, and the output that was waiting never rises.
- R7: `out_a` and `out_b` are never high in the same cycle.
- R8: While disabled, both outputs are low, any interval in progress is abandoned, and the count holds its value except when the period is written.
- R9: While disabled, a write to the period address loads the same value into the count.
- R10: While enabled, a period write does not alter the running count. The count takes the new period only when it reloads, which happens at terminal count or at the next reference edge.
- R11: While disabled, a read of address 0 returns 00h and copies the count into the buffer. While enabled, the same read returns 00h and leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ref_in | input | 1 | PWM reference, synchronous to clk |
| out_a | output | 1 | High-phase output with dead band |
| out_b | output | 1 | Low-phase output with dead band |

## Verification
The assertions assume that `ref_in` is already synchronous to `clk` and that `wr_en` and `rd_en` are never high together. The bench changes every input half a cycle away from the rising edge and issues one bus operation at a time. It reads the count only through the buffer snapshot, so each value it expects for the count comes from the behaviour at the ports.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_COUNT  = 2'd0,
    ADR_PERIOD = 2'd1,
    ADR_BUFFER = 2'd2,
    ADR_CTRL   = 2'd3
  } dbt_addr_e;
endpackage

// File: rtl/dbt_regs.sv
module dbt_regs
  import dbt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     count_val,
  output logic              enable,
  output logic [DW-1:0]     period,
  output logic              per_load,
  output logic [DW-1:0]     buffer,
  output logic [DW-1:0]     rdata
);
  logic          en_n;
  logic [DW-1:0] per_n, buf_n;
  logic          snap;

  // the count is copied into the buffer on a read of address 0, but only while disabled
  assign snap     = rd_en && !wr_en && (addr == ADR_COUNT) && !enable;
  assign per_load = wr_en && (addr == ADR_PERIOD) && !enable;

  always_comb begin
    en_n  = enable;
    per_n = period;
    buf_n = buffer;
    if (wr_en) begin
      unique case (addr)
        ADR_PERIOD: per_n = wdata;
        ADR_BUFFER: buf_n = wdata;
        ADR_CTRL:   en_n  = wdata[0];
        default:    ;
      endcase
    end else if (snap) begin
      buf_n = count_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      period <= '0;
      buffer <= '0;
    end else begin
      enable <= en_n;
      period <= per_n;
      buffer <= buf_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        ADR_BUFFER: rdata = buffer;
        ADR_CTRL:   rdata = {{(DW-1){1'b0}}, enable};
        default:    rdata = '0;
      endcase
    end
  end

  // R11: snapshot lands in buffer
  p_snapshot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> buffer == $past(count_val));
  // R11: enabled count read leaves buffer alone
  p_no_snap_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == ADR_COUNT && enable) |=> $stable(buffer));
  // R2: period address never reads back
  p_period_wo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_PERIOD) |-> rdata == '0);
endmodule

// File: rtl/dbt_counter.sv
module dbt_counter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          ref_in,
  input  logic          per_load,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] count,
  output logic          busy,
  output logic          level
);
  logic          ref_q;
  logic          ref_edge;
  logic          tc;
  logic [DW-1:0] cnt_n;
  logic          busy_n;

  assign level    = ref_q;
  assign ref_edge = enable && (ref_in != ref_q);
  assign tc       = busy && (count == '0);

  always_comb begin
    cnt_n  = count;
    busy_n = busy;
    if (!enable) begin
      busy_n = 1'b0;
      if (per_load) cnt_n = load_val;
    end else if (ref_edge) begin
      busy_n = 1'b1;
      cnt_n  = period;
    end else if (busy) begin
      if (tc) begin
        busy_n = 1'b0;
        cnt_n  = period;
      end else begin
        cnt_n = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      count <= '0;
      busy  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      count <= cnt_n;
      busy  <= busy_n;
    end
  end

  // R9: disabled period write preloads the count
  p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && per_load) |=> count == $past(load_val));
  // R8: disabled count holds
  p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !per_load) |=> $stable(count));
  // R10: reload from period at terminal count
  p_tc_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tc && !ref_edge) |=> (count == $past(period)) && !busy);
  // R6: each edge restarts the interval
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |=> busy && count == $past(period));
  // R3: counter steps down by one inside an interval
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && busy && !tc && !ref_edge) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/dbt_outstage.sv
module dbt_outstage (
  input  logic enable,
  input  logic level,
  input  logic busy,
  output logic out_a,
  output logic out_b
);
  logic quiet;

  assign quiet = enable && !busy;
  assign out_a = quiet && level;
  assign out_b = quiet && !level;
endmodule

// File: rtl/deadband_timer.sv
module deadband_timer
  import dbt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              ref_in,
  output logic              out_a,
  output logic              out_b
);
  logic [1:0]    rst_sync;
  logic          rst_ns;
  logic          enable, per_load, busy, level;
  logic [DW-1:0] period, count, buffer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  dbt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count_val(count), .enable(enable), .period(period),
    .per_load(per_load), .buffer(buffer), .rdata(rdata)
  );

  dbt_counter #(.DW(DW)) u_counter (
    .clk(clk), .rst_n(rst_ns), .enable(enable), .ref_in(ref_in),
    .per_load(per_load), .load_val(wdata), .period(period),
    .count(count), .busy(busy), .level(level)
  );

  dbt_outstage u_out (
    .enable(enable), .level(level), .busy(busy), .out_a(out_a), .out_b(out_b)
  );

  // R7: outputs never overlap
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !(out_a && out_b));
  // R8: disabled slice drives nothing
  p_disabled_low_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !enable |-> (!out_a && !out_b));
  // R3: a reference edge pulls both outputs low on the next cycle
  p_edge_low_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (enable && (ref_in != level)) |=> (!out_a && !out_b));
endmodule

// File: tb/test_deadband_timer.sv
module test_deadband_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ref_in = 1'b0;
  logic       out_a, out_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  deadband_timer i_deadband_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ref_in(ref_in), .out_a(out_a), .out_b(out_b)
  );

  // overlap watcher for R7
  always @(negedge clk) begin
    if (rst_n && out_a && out_b) begin
      errors++;
      $display("FAIL R7: out_a=%0b out_b=%0b expected not both high", out_a, out_b);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ref_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // drive ref to lvl and count cycles with both outputs low until target rises
  task automatic measure(input logic lvl, output int lows, output bit other_rose);
    ref_in = lvl;
    lows = 0; other_rose = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if ((lvl ? out_a : out_b)) break;
      if ((lvl ? out_b : out_a)) other_rose = 1'b1;
      lows++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check(!out_a && !out_b, "R1 outputs", {out_a, out_b}, 0);
    for (int a = 0; a < 4; a++) begin
      bus_rd(a[1:0], d);
      check(d == 8'h00, "R1 read", d, 0);
    end
    bus_rd(2'd0, d);
    bus_rd(2'd2, d);
    check(d == 8'h00, "R1 count via buffer", d, 0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    do_reset();
    bus_wr(2'd2, 8'hA5);
    bus_rd(2'd2, d);
    check(d == 8'hA5, "R2 buffer rw", d, 8'hA5);
    bus_wr(2'd1, 8'h33);
    bus_rd(2'd1, d);
    check(d == 8'h00, "R2 period write only", d, 0);
    bus_wr(2'd3, 8'hFF);
    bus_rd(2'd3, d);
    check(d == 8'h01, "R2 ctrl readback", d, 1);
    #1 check(rdata == 8'h00, "R2 rdata idle", rdata, 0);
  endtask

  task automatic t_rise(input logic [7:0] p, input string req);
    int lows; bit oth;
    do_reset();
    bus_wr(2'd1, p);
    bus_wr(2'd3, 8'h01);
    @(negedge clk);
    check(out_b && !out_a, {req, " idle low phase"}, {out_a, out_b}, 1);
    measure(1'b1, lows, oth);
    check(lows == int'(p) + 1, {req, " rising dead band"}, lows, int'(p) + 1);
    check(out_a && !oth, {req, " out_a high after"}, out_a, 1);
  endtask

  task automatic t_fall();
    int lows; bit oth;
    do_reset();
    bus_wr(2'd1, 8'd6);
    bus_wr(2'd3, 8'h01);
    ref_in = 1'b1;
    repeat (10) @(negedge clk);
    check(out_a, "R5 high phase", out_a, 1);
    measure(1'b0, lows, oth);
    check(lows == 7, "R5 falling dead band", lows, 7);
    check(out_b && !oth, "R5 out_b high after", out_b, 1);
  endtask

  task automatic t_retrig();
    int lows; bit oth;
    do_reset();
    bus_wr(2'd1, 8'd5);
    bus_wr(2'd3, 8'h01);
    ref_in = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!out_a && !out_b, "R6 low before retrigger", {out_a, out_b}, 0);
    end
    measure(1'b0, lows, oth);
    check(lows == 6, "R6 full interval after retrigger", lows, 6);
    check(!oth, "R6 out_a never rose", oth, 0);
  endtask

  task automatic t_disable();
    logic [7:0] d1, d2;
    do_reset();
    bus_wr(2'd1, 8'd40);
    bus_wr(2'd3, 8'h01);
    ref_in = 1'b1;
    repeat (5) @(negedge clk);
    bus_wr(2'd3, 8'h00);
    check(!out_a && !out_b, "R8 outputs low disabled", {out_a, out_b}, 0);
    bus_rd(2'd0, d1);
    check(d1 == 8'h00, "R11 disabled count reads zero", d1, 0);
    bus_rd(2'd2, d1);
    ref_in = 1'b0;
    repeat (6) begin
      @(negedge clk);
      check(!out_a && !out_b, "R8 low while ref toggles", {out_a, out_b}, 0);
      ref_in = ~ref_in;
    end
    bus_rd(2'd0, d2);
    bus_rd(2'd2, d2);
    check(d2 == d1, "R8 count holds", d2, d1);
    check(d1 < 8'd40 && d1 > 8'd30, "R8 count mid-interval", d1, 35);
  endtask

  task automatic t_preload();
    logic [7:0] d;
    do_reset();
    bus_wr(2'd1, 8'h5A);
    bus_rd(2'd0, d);
    bus_rd(2'd2, d);
    check(d == 8'h5A, "R9 preload", d, 8'h5A);
  endtask

  task automatic t_enabled_write();
    logic [7:0] d;
    int lows;
    do_reset();
    bus_wr(2'd1, 8'd10);
    bus_wr(2'd3, 8'h01);
    bus_wr(2'd1, 8'd3);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, d);
    bus_rd(2'd2, d);
    check(d == 8'd10, "R10 idle write does not load", d, 10);
    bus_wr(2'd1, 8'd10);
    bus_wr(2'd3, 8'h01);
    ref_in = 1'b1;
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i == 2) begin wr_en = 1'b1; addr = 2'd1; wdata = 8'd3; end
      if (i == 3) wr_en = 1'b0;
      if (out_a) break;
      lows++;
    end
    check(lows == 11, "R10 running count unchanged", lows, 11);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, d);
    bus_rd(2'd2, d);
    check(d == 8'd3, "R10 reload at terminal count", d, 3);
  endtask

  task automatic t_enabled_read();
    logic [7:0] d;
    do_reset();
    bus_wr(2'd1, 8'd9);
    bus_wr(2'd2, 8'h77);
    bus_wr(2'd3, 8'h01);
    bus_rd(2'd0, d);
    check(d == 8'h00, "R11 enabled count reads zero", d, 0);
    bus_rd(2'd2, d);
    check(d == 8'h77, "R11 enabled read no snapshot", d, 8'h77);
  endtask

  initial begin
    t_reset();
    t_map();
    t_rise(8'd4, "R3");
    t_rise(8'd0, "R4");
    t_rise(8'd17, "R3");
    t_fall();
    t_retrig();
    t_disable();
    t_preload();
    t_enabled_write();
    t_enabled_read();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule